// File: doc/BRIEF.md
# Byte-Sequence Unlock Guard

The guard watches every byte written to one I/O port and keeps a single lock flag. The flag decides whether a secondary mapping register, which selects an extended register page for the processor address space, may be written. To change the flag, software first writes a two-byte preamble: any nonzero byte, then 0x00. It then writes a fixed 13-byte key. The byte after the key picks the outcome. The value 0xCD, followed by one more write of any value, unlocks the guard. Any other value locks it at once.

The key is not stored in a table. It comes from two 4-bit shift registers, one for the high nibbles and one for the low nibbles. Both start from all ones. A key byte that does not match returns the tracker to idle, or to the preamble's first step if that byte is nonzero. Locking and unlocking never clear the page select bit. A page left mapped stays mapped after locking, and it can be unmapped only after a new unlock.

The port has no back-pressure. Every write strobe is taken on the rising edge where it is high, so no ready signal is needed. Reset is synchronous and active low.

Top module: `key_seq_guard`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `unlocked` is 0 and `page_sel` is 0.
- R2: A preamble is one strobed nonzero byte followed by a strobed 0x00. Further nonzero bytes before the 0x00 keep the tracker waiting for the zero. A 0x00 written while idle has no effect.
- R3: After the preamble, the key bytes must be 0xFF, 0x77, 0xB3, 0x51, 0xA8, 0xD4, 0x62, 0x39, 0x9C, 0x46, 0x2B, 0x15, 0x8A, in that order.
- R4: If 0xCD follows the key, and then one more strobed write of any value arrives, `unlocked` is 1 from the cycle after that last write.
- R5: If any byte other than 0xCD follows the key, `unlocked` is 0 from the cycle after that byte.
- R6: A wrong key byte leaves `unlocked` unchanged. If that byte is nonzero, it starts a new preamble. If it is 0x00, including a second 0x00 straight after the preamble, the tracker returns to idle.
- R7: While `unlocked` is 0, `map_wr_en` stays 0 and `page_sel` keeps its value whatever `map_wr_stb` does.
- R8: While `unlocked` is 1, `map_wr_en` equals `map_wr_stb`. A map write loads `map_wr_bit` into `page_sel`, visible on the next cycle.
- R9: Locking and unlocking leave `page_sel` unchanged.
- R10: A byte on `wr_data` without `wr_stb` has no effect on the tracker or on `unlocked`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_stb | input | 1 | Strobe for a byte written to the watched port |
| wr_data | input | 8 | Byte written to the watched port |
| map_wr_stb | input | 1 | Write request to the secondary mapping register |
| map_wr_bit | input | 1 | Page select value for that write |
| unlocked | output | 1 | 1 when the guard is unlocked |
| page_sel | output | 1 | Current register page select bit |
| map_wr_en | output | 1 | Mapping-register write enable, passed only while unlocked |

## Verification
The assertions assume that `rst_n` is held low for at least two clock edges before it is first released, so that every `$past` sample already holds a reset value. They also assume that `wr_data` and `map_wr_bit` carry known values on every edge where their strobes are high. The stimulus holds reset for four cycles. It changes inputs only one time unit after a rising edge, and it drives defined values at all times. It returns both strobes to 0 between sequences, so any write the tracker sees is one the stimulus intended.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;
  typedef enum logic [2:0] {
    TRK_IDLE   = 3'd0,
    TRK_PRE    = 3'd1,
    TRK_KEY    = 3'd2,
    TRK_DECIDE = 3'd3,
    TRK_FINISH = 3'd4
  } trk_state_t;

  // Mask of the bits whose exclusive-or feeds back into one nibble's top bit.
  function automatic logic lane_feedback(input logic [3:0] nib, input logic [3:0] taps);
    return ^(nib & taps);
  endfunction
endpackage

// File: rtl/key_lfsr_gen.sv
module key_lfsr_gen #(
  parameter int               NIB_W = 4,
  parameter int               LANES = 2,
  parameter logic [7:0]       SEED  = 8'hFF,
  parameter logic [7:0]       TAPS  = {4'b1001, 4'b0011}
) (
  input  logic                    clk,
  input  logic                    load,
  input  logic                    step,
  output logic [LANES*NIB_W-1:0]  key_byte
);
  import keyseq_pkg::*;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [NIB_W-1:0] nib_q;
      always_ff @(posedge clk) begin
        if (load)
          nib_q <= SEED[g*NIB_W +: NIB_W];
        else if (step)
          nib_q <= {lane_feedback(nib_q, TAPS[g*NIB_W +: NIB_W]), nib_q[NIB_W-1:1]};
      end
      assign key_byte[g*NIB_W +: NIB_W] = nib_q;
    end
  endgenerate
endmodule

// File: rtl/seq_tracker.sv
module seq_tracker #(
  parameter int         DATA_W  = 8,
  parameter int         KEY_LEN = 13,
  parameter logic [7:0] SEED    = 8'hFF,
  localparam int        IDX_W   = $clog2(KEY_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] key_byte,
  output logic              gen_load,
  output logic              gen_step,
  output logic              unlocked
);
  import keyseq_pkg::*;

  trk_state_t state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic unl_d;
  logic is_zero, hit, last_key;

  assign is_zero  = (wr_data == '0);
  assign hit      = (wr_data == key_byte);
  assign last_key = (idx_q == IDX_W'(KEY_LEN - 1));

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    unl_d    = unlocked;
    gen_load = 1'b0;
    gen_step = 1'b0;
    if (wr_stb) begin
      unique case (state_q)
        TRK_IDLE: if (!is_zero) state_d = TRK_PRE;
        TRK_PRE: if (is_zero) begin
          state_d  = TRK_KEY;
          idx_d    = '0;
          gen_load = 1'b1;
        end
        TRK_KEY: begin
          if (hit) begin
            gen_step = 1'b1;
            if (last_key) state_d = TRK_DECIDE;
            else idx_d = idx_q + 1'b1;
          end else begin
            state_d = is_zero ? TRK_IDLE : TRK_PRE;
          end
        end
        TRK_DECIDE: begin
          if (hit) state_d = TRK_FINISH;
          else begin
            state_d = TRK_IDLE;
            unl_d   = 1'b0;
          end
        end
        TRK_FINISH: begin
          state_d = TRK_IDLE;
          unl_d   = 1'b1;
        end
        default: state_d = TRK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= TRK_IDLE;
      idx_q    <= '0;
      unlocked <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      unlocked <= unl_d;
    end
  end

  p_key_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(KEY_LEN));
  p_key_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TRK_PRE && wr_stb && wr_data == '0) |=> (state_q == TRK_KEY && key_byte == SEED));
  p_unlock_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(state_q == TRK_FINISH && wr_stb));
  p_lock_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked) |-> $past(state_q == TRK_DECIDE && wr_stb && wr_data != key_byte));
  p_no_strobe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(state_q) && $stable(unlocked)));
endmodule

// File: rtl/page_gate.sv
module page_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic unlocked,
  input  logic map_wr_stb,
  input  logic map_wr_bit,
  output logic page_sel,
  output logic map_wr_en
);
  assign map_wr_en = map_wr_stb & unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) page_sel <= 1'b0;
    else if (map_wr_en) page_sel <= map_wr_bit;
  end

  p_locked_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(unlocked) |-> $stable(page_sel));
  p_unlocked_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (map_wr_stb && unlocked) |=> (page_sel == $past(map_wr_bit)));
endmodule

// File: rtl/key_seq_guard.sv
module key_seq_guard #(
  parameter int         DATA_W  = 8,
  parameter int         KEY_LEN = 13,
  parameter logic [7:0] SEED    = 8'hFF,
  parameter logic [7:0] TAPS    = {4'b1001, 4'b0011}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              map_wr_stb,
  input  logic              map_wr_bit,
  output logic              unlocked,
  output logic              page_sel,
  output logic              map_wr_en
);
  localparam int NIB_W = 4;
  localparam int LANES = DATA_W / NIB_W;

  logic [DATA_W-1:0] key_byte;
  logic gen_load, gen_step;

  key_lfsr_gen #(.NIB_W(NIB_W), .LANES(LANES), .SEED(SEED), .TAPS(TAPS)) u_gen (
    .clk(clk), .load(gen_load), .step(gen_step), .key_byte(key_byte)
  );

  seq_tracker #(.DATA_W(DATA_W), .KEY_LEN(KEY_LEN), .SEED(SEED)) u_trk (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .key_byte(key_byte), .gen_load(gen_load), .gen_step(gen_step),
    .unlocked(unlocked)
  );

  page_gate u_gate (
    .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .map_wr_stb(map_wr_stb),
    .map_wr_bit(map_wr_bit), .page_sel(page_sel), .map_wr_en(map_wr_en)
  );
endmodule

// File: tb/test_key_seq_guard.sv
`timescale 1ns/1ps
module test_key_seq_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic map_wr_stb = 1'b0;
  logic map_wr_bit = 1'b0;
  logic unlocked, page_sel, map_wr_en;

  always #5 clk = ~clk;

  key_seq_guard i_key_seq_guard (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .map_wr_stb(map_wr_stb), .map_wr_bit(map_wr_bit),
    .unlocked(unlocked), .page_sel(page_sel), .map_wr_en(map_wr_en)
  );

  logic [7:0] seq [0:13] = '{8'hFF, 8'h77, 8'hB3, 8'h51, 8'hA8, 8'hD4, 8'h62,
                             8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A, 8'hCD};

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference: 0 idle, 1 seen nonzero, 2 in key, 3 choosing, 4 last write
  int m_phase = 0;
  int m_pos = 0;
  bit m_unl = 1'b0;
  bit m_page = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_pos = 0; m_unl = 1'b0; m_page = 1'b0;
    end else begin
      if (map_wr_stb && m_unl) m_page = map_wr_bit;
      if (wr_stb) begin
        if (m_phase == 0) begin
          if (wr_data != 0) m_phase = 1;
        end else if (m_phase == 1) begin
          if (wr_data == 0) begin m_phase = 2; m_pos = 0; end
        end else if (m_phase == 2) begin
          if (wr_data == seq[m_pos]) begin
            m_pos++;
            if (m_pos == 13) m_phase = 3;
          end else m_phase = (wr_data != 0) ? 1 : 0;
        end else if (m_phase == 3) begin
          if (wr_data == seq[13]) m_phase = 4;
          else begin m_unl = 1'b0; m_phase = 0; end
        end else begin
          m_unl = 1'b1; m_phase = 0;
        end
      end
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("unlocked", unlocked, rst_n ? m_unl : 1'b0);
      chk("page_sel", page_sel, rst_n ? m_page : 1'b0);
      chk("map_wr_en", map_wr_en, rst_n ? (map_wr_stb & m_unl) : 1'b0);
    end
  end

  task automatic cyc(input bit s, input logic [7:0] d, input bit ms, input bit mb);
    @(posedge clk); #1;
    wr_stb = s; wr_data = d; map_wr_stb = ms; map_wr_bit = mb;
  endtask
  task automatic wr(input logic [7:0] d); cyc(1'b1, d, 1'b0, 1'b0); endtask
  task automatic mw(input bit b); cyc(1'b0, 8'h00, 1'b1, b); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0);
  endtask
  task automatic key_only();
    for (int i = 0; i < 13; i++) wr(seq[i]);
  endtask
  task automatic do_unlock();
    wr(8'h5A); wr(8'h00); key_only(); wr(8'hCD); wr(8'h3C); idle(2);
  endtask
  task automatic do_lock(input logic [7:0] last);
    wr(8'h01); wr(8'h00); key_only(); wr(last); idle(2);
  endtask
  task automatic expect_unl(input bit e);
    @(negedge clk); chk("direct unlocked", unlocked, e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    idle(4);
    @(posedge clk); #1; rst_n = 1'b1;
    idle(2); expect_unl(1'b0);

    cur_req = "R7";
    mw(1'b1); mw(1'b1); idle(1);
    @(negedge clk); chk("page frozen", page_sel, 1'b0);

    cur_req = "R10";
    for (int i = 0; i < 16; i++) cyc(1'b0, (i == 0) ? 8'h5A : (i == 1) ? 8'h00 : seq[i-2], 1'b0, 1'b0);
    idle(2); expect_unl(1'b0);

    cur_req = "R2";
    wr(8'h00); wr(8'h00); wr(8'h05); wr(8'h07); wr(8'h00); key_only();
    cur_req = "R4";
    wr(8'hCD); wr(8'h00); idle(1); expect_unl(1'b1);

    cur_req = "R8";
    mw(1'b1); idle(1);
    @(negedge clk); chk("page set", page_sel, 1'b1);

    cur_req = "R5";
    do_lock(8'h12); expect_unl(1'b0);
    cur_req = "R9";
    @(negedge clk); chk("page kept after lock", page_sel, 1'b1);
    cur_req = "R7";
    mw(1'b0); idle(1);
    @(negedge clk); chk("page not cleared while locked", page_sel, 1'b1);

    cur_req = "R3";
    wr(8'h09); wr(8'h00); wr(8'hFF); wr(8'h77); wr(8'hB4);
    wr(8'h8A); wr(8'hCD); wr(8'h00); idle(1); expect_unl(1'b0);

    cur_req = "R6";
    wr(8'h09); wr(8'h00); wr(8'hFF); wr(8'h33); wr(8'h00);
    key_only(); wr(8'hCD); wr(8'hEE); idle(1); expect_unl(1'b1);
    cur_req = "R9";
    @(negedge clk); chk("page kept after unlock", page_sel, 1'b1);

    cur_req = "R8";
    mw(1'b0); idle(1);
    @(negedge clk); chk("page cleared", page_sel, 1'b0);

    cur_req = "R6";
    wr(8'h01); wr(8'h00); wr(8'h00); key_only(); wr(8'h44); idle(1);
    expect_unl(1'b1);
    wr(8'h01); wr(8'h00); for (int i = 0; i < 6; i++) wr(seq[i]); wr(8'h00);
    wr(8'h99); idle(1); expect_unl(1'b1);

    cur_req = "R5";
    do_lock(8'h00); expect_unl(1'b0);
    cur_req = "R4";
    do_unlock(); expect_unl(1'b1);
    cur_req = "R8";
    cyc(1'b1, 8'h77, 1'b1, 1'b1); idle(1);
    cur_req = "R5";
    do_lock(8'hCC); expect_unl(1'b0);
    cur_req = "R7";
    mw(1'b0); idle(2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule